// File: doc/BRIEF.md
# Variable-Length Instruction Predecoder

This block sits between instruction fetch and decode in a processor that runs either fixed 32-bit instructions or a compressed stream of 16-bit and 32-bit instructions. Fetch delivers one 32-bit word at a time, and the block breaks it into whole instructions. It keeps a byte offset inside the held word, picks the next halfword, works out the instruction length from that halfword's top bits, and puts the instruction together. A 32-bit compressed instruction may begin in the upper halfword of one fetch word and end in the lower halfword of the next. When that happens the first half is parked until the next word arrives.

Two flags are kept apart. One says an instruction is waiting (`insn_ready_o`). The other says the held word is used up and fetch must supply another (`need_more_o`). Decode pops the waiting instruction with `take_i`. Each compressed instruction can also carry an 8-bit conditional-block state. This state is captured with each fetch word and steps forward once per finished compressed instruction while its mask is nonzero.

Top module: `vlp_predecoder`

## Requirements
- R1: After reset, `need_more_o` is 1, `insn_ready_o` is 0 and `insn_o` is 0.
- R2: A fetch word is accepted only in a cycle where `word_valid_i` and `need_more_o` are both high. `need_more_o` is then low in the next cycle and the byte offset restarts at 0. A `word_valid_i` while `need_more_o` is low is ignored.
- R3: In full-width mode (`narrow_mode_i`=0 at load), one cycle after the load the whole word is presented. `insn_size_o`=4 and `cond_o` equals word bits 31:28. All 4 bytes are consumed.
- R4: In compressed mode the halfword at byte offset 0 is word bits 15:0, and the halfword at offset 2 is bits 31:16.
- R5: A halfword starts a 32-bit compressed instruction when its bits 15:11 are 11101, 11110 or 11111. Any other value is a complete 16-bit instruction.
- R6: A 16-bit compressed instruction is presented as {16'h0, halfword} with `insn_size_o`=2 and `cond_o`=4'hE (unconditional), and consumes 2 bytes. Every compressed instruction presents `cond_o`=4'hE.
- R7: A 32-bit compressed instruction that starts at offset 0 is presented as {bits 15:0, bits 31:16} of the word, with size 4, and consumes 4 bytes.
- R8: A 32-bit compressed instruction that starts at offset 2 stores its first halfword, consumes 2 bytes, and leaves `insn_ready_o` low. The first halfword of the next accepted word completes it as {first, second} with size 4.
- R9: The offset never exceeds 4. `need_more_o` is high exactly when the held word has been fully consumed (or after reset).
- R10: `take_i` with `insn_ready_o` high clears `insn_ready_o` and `insn_o` at the next edge. The next instruction from remaining bytes appears one cycle after that. `take_i` while not ready is a protocol violation and has no effect.
- R11: The conditional-block state is {`cb_hi_i`, `cb_lo_i`}, captured at each accepted load. When its low 4 bits are nonzero, each finished compressed instruction is tagged with it (`cb_tag_valid_o`=1). The state then advances: it becomes 0 if bits 2:0 are 0, otherwise bits 4:0 shift left by one and bits 7:5 are kept. Full-width instructions are never tagged.
- R12: A ready instruction and its size stay unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_valid_i | input | 1 | Fetch word offered |
| word_i | input | 32 | Fetch word |
| narrow_mode_i | input | 1 | 1 = compressed mode for this word |
| cb_hi_i | input | 6 | Conditional-block state, upper field |
| cb_lo_i | input | 2 | Conditional-block state, lower field |
| take_i | input | 1 | Decode pops the ready instruction |
| insn_o | output | 32 | Assembled instruction |
| insn_ready_o | output | 1 | Instruction valid |
| insn_size_o | output | 3 | Instruction size in bytes (2 or 4) |
| cond_o | output | 4 | Condition field |
| cb_tag_o | output | 8 | Conditional-block tag |
| cb_tag_valid_o | output | 1 | Tag present |
| need_more_o | output | 1 | Held word used up; next fetch word wanted |

## Verification
The hardest case to reach is a 32-bit compressed instruction that straddles two words. It requires a 16-bit instruction at offset 0, then a wide first half at offset 2, and then a new word offered only after `need_more_o` rises. The directed part builds this case explicitly. It also offers a word while `need_more_o` is low at that point and shows that the pending half still joins with the correct word. A random phase then mixes mode, instruction length and conditional-block state, with take and load timing chosen by coin flips. Every cycle is compared against a behavioural model, so straddles also occur back to back and while a pop is held off.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam logic [3:0] COND_ALWAYS = 4'hE;

  // Prefixes 11101, 11110, 11111 mark the first half of a 32-bit compressed insn
  function automatic logic is_wide_half(input logic [15:0] hw);
    return (hw[15:13] == 3'b111) && (hw[12:11] != 2'b00);
  endfunction

  function automatic logic [7:0] cb_step(input logic [7:0] st);
    if (st[2:0] == 3'b000) return 8'h00;
    return {st[7:5], st[3:0], 1'b0};
  endfunction
endpackage

// File: rtl/vlp_half_sel.sv
module vlp_half_sel #(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 3
) (
  input  logic [WORD_W-1:0]   word_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [WORD_W/2-1:0] half_o,
  output logic                wide_o
);
  localparam int HALF_W = WORD_W / 2;
  localparam int HALVES = WORD_W / HALF_W;

  logic [HALF_W-1:0] halves [HALVES];

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    assign halves[g] = word_i[g*HALF_W +: HALF_W];
  end

  assign half_o = halves[off_i[OFF_W-2:1]];
  assign wide_o = vlp_pkg::is_wide_half(half_o);
endmodule

// File: rtl/vlp_byte_ctr.sv
module vlp_byte_ctr #(
  parameter int BYTES = 4,
  parameter int OFF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             consume_i,
  input  logic [OFF_W-1:0] amt_i,
  output logic [OFF_W-1:0] off_o,
  output logic             oob_o
);
  logic [OFF_W-1:0] off_nxt;
  assign off_nxt = off_o + amt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o <= '0;
      oob_o <= 1'b1;
    end else if (load_i) begin
      off_o <= '0;
      oob_o <= 1'b0;
    end else if (consume_i) begin
      off_o <= off_nxt;
      if (off_nxt == OFF_W'(BYTES)) oob_o <= 1'b1;
    end
  end
endmodule

// File: rtl/vlp_cb_track.sv
module vlp_cb_track #(
  parameter int HI_W = 6,
  parameter int LO_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic [LO_W-1:0]      lo_i,
  input  logic                 adv_i,
  output logic [HI_W+LO_W-1:0] state_o,
  output logic                 active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= '0;
    else if (load_i)  state_o <= {hi_i, lo_i};
    else if (adv_i)   state_o <= vlp_pkg::cb_step(state_o);
  end

  assign active_o = (state_o[3:0] != 4'h0);
endmodule

// File: rtl/vlp_predecoder.sv
module vlp_predecoder #(
  parameter int WORD_W  = 32,
  parameter int CB_HI_W = 6,
  parameter int CB_LO_W = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       word_valid_i,
  input  logic [WORD_W-1:0]          word_i,
  input  logic                       narrow_mode_i,
  input  logic [CB_HI_W-1:0]         cb_hi_i,
  input  logic [CB_LO_W-1:0]         cb_lo_i,
  input  logic                       take_i,
  output logic [WORD_W-1:0]          insn_o,
  output logic                       insn_ready_o,
  output logic [2:0]                 insn_size_o,
  output logic [3:0]                 cond_o,
  output logic [CB_HI_W+CB_LO_W-1:0] cb_tag_o,
  output logic                       cb_tag_valid_o,
  output logic                       need_more_o
);
  import vlp_pkg::*;

  localparam int HALF_W     = WORD_W / 2;
  localparam int BYTES      = WORD_W / 8;
  localparam int HALF_BYTES = BYTES / 2;
  localparam int OFF_W      = $clog2(BYTES) + 1;
  localparam int CB_W       = CB_HI_W + CB_LO_W;

  logic [WORD_W-1:0] word_q;
  logic              narrow_q;
  logic              pend_q;
  logic [HALF_W-1:0] hi_q;
  logic [OFF_W-1:0]  off_q;
  logic              oob_q;
  logic              load, step, take_ok;
  logic [HALF_W-1:0] half;
  logic              wide;
  logic [CB_W-1:0]   cb_state;
  logic              cb_active;

  logic [OFF_W-1:0]  amt;
  logic              complete, set_pend, clr_pend, cb_adv;
  logic [WORD_W-1:0] nxt_insn;
  logic [2:0]        nxt_size;
  logic [3:0]        nxt_cond;

  assign load    = word_valid_i && oob_q;
  assign step    = !oob_q && !insn_ready_o;
  assign take_ok = take_i && insn_ready_o;

  vlp_half_sel #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_sel (
    .word_i (word_q),
    .off_i  (off_q),
    .half_o (half),
    .wide_o (wide)
  );

  vlp_byte_ctr #(.BYTES(BYTES), .OFF_W(OFF_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .consume_i (step),
    .amt_i     (amt),
    .off_o     (off_q),
    .oob_o     (oob_q)
  );

  vlp_cb_track #(.HI_W(CB_HI_W), .LO_W(CB_LO_W)) u_cb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .hi_i     (cb_hi_i),
    .lo_i     (cb_lo_i),
    .adv_i    (cb_adv),
    .state_o  (cb_state),
    .active_o (cb_active)
  );

  always_comb begin
    amt      = '0;
    complete = 1'b0;
    set_pend = 1'b0;
    clr_pend = 1'b0;
    nxt_insn = '0;
    nxt_size = 3'(BYTES);
    nxt_cond = COND_ALWAYS;
    if (!narrow_q) begin
      amt      = OFF_W'(BYTES);
      complete = 1'b1;
      nxt_insn = word_q;
      nxt_cond = word_q[WORD_W-1 -: 4];
    end else if (pend_q) begin
      amt      = OFF_W'(HALF_BYTES);
      complete = 1'b1;
      clr_pend = 1'b1;
      nxt_insn = {hi_q, half};
    end else if (wide && off_q == '0) begin
      amt      = OFF_W'(BYTES);
      complete = 1'b1;
      nxt_insn = {word_q[HALF_W-1:0], word_q[WORD_W-1:HALF_W]};
    end else if (wide) begin
      amt      = OFF_W'(HALF_BYTES);
      set_pend = 1'b1;
    end else begin
      amt      = OFF_W'(HALF_BYTES);
      complete = 1'b1;
      nxt_insn = {{HALF_W{1'b0}}, half};
      nxt_size = 3'(HALF_BYTES);
    end
  end

  assign cb_adv = step && complete && narrow_q && cb_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= '0;
      narrow_q <= 1'b0;
      pend_q   <= 1'b0;
      hi_q     <= '0;
    end else begin
      if (load) begin
        word_q   <= word_i;
        narrow_q <= narrow_mode_i;
      end
      if (step && set_pend) begin
        pend_q <= 1'b1;
        hi_q   <= half;
      end else if (step && clr_pend) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      insn_o         <= '0;
      insn_ready_o   <= 1'b0;
      insn_size_o    <= '0;
      cond_o         <= '0;
      cb_tag_o       <= '0;
      cb_tag_valid_o <= 1'b0;
    end else if (take_ok) begin
      insn_o         <= '0;
      insn_ready_o   <= 1'b0;
      cb_tag_o       <= '0;
      cb_tag_valid_o <= 1'b0;
    end else if (step && complete) begin
      insn_o         <= nxt_insn;
      insn_ready_o   <= 1'b1;
      insn_size_o    <= nxt_size;
      cond_o         <= nxt_cond;
      cb_tag_valid_o <= narrow_q && cb_active;
      cb_tag_o       <= (narrow_q && cb_active) ? cb_state : '0;
    end
  end

  assign need_more_o = oob_q;
endmodule

// File: rtl/vlp_predecoder_chk.sv
module vlp_predecoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_valid_i,
  input logic        take_i,
  input logic [31:0] insn_o,
  input logic        insn_ready_o,
  input logic [2:0]  insn_size_o,
  input logic [3:0]  cond_o,
  input logic        need_more_o,
  input logic [2:0]  off_q
);
  AST_TAKE_WHEN_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> insn_ready_o);  // R10
  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && insn_ready_o |=> !insn_ready_o && insn_o == 32'h0);  // R10
  AST_LOAD_REFILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && need_more_o |=> !need_more_o);  // R2
  AST_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= 3'd4);  // R9
  AST_BYTES_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !need_more_o |-> off_q < 3'd4);  // R9
  AST_HOLD_UNTIL_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_ready_o && !take_i |=> insn_ready_o && $stable(insn_o) && $stable(insn_size_o));  // R12
  AST_NARROW_UNCOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_ready_o && insn_size_o == 3'd2 |-> cond_o == 4'hE);  // R6
  AST_SIZE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_ready_o |-> insn_size_o == 3'd2 || insn_size_o == 3'd4);  // R6
endmodule

bind vlp_predecoder vlp_predecoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .take_i       (take_i),
  .insn_o       (insn_o),
  .insn_ready_o (insn_ready_o),
  .insn_size_o  (insn_size_o),
  .cond_o       (cond_o),
  .need_more_o  (need_more_o),
  .off_q        (off_q)
);

// File: tb/vlp_predecoder_tb_top.sv
`timescale 1ns/1ps
module vlp_predecoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wv = 1'b0;
  logic [31:0] word = '0;
  logic        narrow = 1'b0;
  logic [5:0]  cb_hi = '0;
  logic [1:0]  cb_lo = '0;
  logic        take = 1'b0;
  logic [31:0] insn;
  logic        ready;
  logic [2:0]  size;
  logic [3:0]  cond;
  logic [7:0]  tag;
  logic        tag_v;
  logic        need_more;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  vlp_predecoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(wv), .word_i(word),
    .narrow_mode_i(narrow), .cb_hi_i(cb_hi), .cb_lo_i(cb_lo), .take_i(take),
    .insn_o(insn), .insn_ready_o(ready), .insn_size_o(size), .cond_o(cond),
    .cb_tag_o(tag), .cb_tag_valid_o(tag_v), .need_more_o(need_more)
  );

  // behavioural reference
  int m_word, m_narrow, m_off, m_oob, m_pend, m_hi, m_cb;
  int m_ready, m_insn, m_size, m_cond, m_tag, m_tagv;
  int hw, top5;
  bit do_take, do_load, do_proc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 0; m_narrow = 0; m_off = 0; m_oob = 1; m_pend = 0; m_hi = 0; m_cb = 0;
      m_ready = 0; m_insn = 0; m_size = 0; m_cond = 0; m_tag = 0; m_tagv = 0;
    end else begin
      do_take = take && (m_ready != 0);
      do_load = wv && (m_oob != 0);
      do_proc = (m_oob == 0) && (m_ready == 0);
      if (do_take) begin
        m_ready = 0; m_insn = 0; m_tag = 0; m_tagv = 0;
      end
      if (do_proc) begin
        hw = (m_word >>> (8 * m_off)) & 'hFFFF;
        top5 = (hw >> 11) & 'h1F;
        if (m_narrow == 0) begin
          m_insn = m_word; m_size = 4; m_cond = (m_word >>> 28) & 'hF;
          m_ready = 1; m_tagv = 0; m_tag = 0; m_off += 4;
        end else if (m_pend != 0 || top5 >= 29 || top5 == 0 && 0) begin
          if (m_pend != 0) begin
            m_insn = (m_hi << 16) | hw; m_pend = 0; m_off += 2; m_ready = 1;
          end else if (m_off == 0) begin
            m_insn = ((m_word & 'hFFFF) << 16) | ((m_word >>> 16) & 'hFFFF);
            m_off += 4; m_ready = 1;
          end else begin
            m_hi = hw; m_pend = 1; m_off += 2;
          end
          m_size = 4; m_cond = 'hE;
        end else begin
          m_insn = hw; m_size = 2; m_cond = 'hE; m_off += 2; m_ready = 1;
        end
        if (m_narrow != 0 && m_ready != 0) begin
          if ((m_cb & 'hF) != 0) begin
            m_tag = m_cb; m_tagv = 1;
            m_cb = ((m_cb & 7) == 0) ? 0 : ((m_cb & 'hE0) | ((m_cb << 1) & 'h1F));
          end else begin
            m_tag = 0; m_tagv = 0;
          end
        end
        if (m_off == 4) m_oob = 1;
      end
      if (do_load) begin
        m_word = word; m_narrow = narrow; m_off = 0; m_oob = 0; m_cb = {cb_hi, cb_lo};
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      n_cmp++;
      if (need_more !== (m_oob != 0)) begin
        n_bad++; $display("FAIL R9 need_more: actual %0d expected %0d", need_more, m_oob);
      end
      if (ready !== (m_ready != 0)) begin
        n_bad++; $display("FAIL R10 ready: actual %0d expected %0d", ready, m_ready);
      end
      if (insn !== 32'(m_insn)) begin
        n_bad++; $display("FAIL R8 insn: actual %0h expected %0h", insn, m_insn);
      end
      if (ready && m_ready != 0) begin
        if (size !== 3'(m_size)) begin
          n_bad++; $display("FAIL R6 size: actual %0d expected %0d", size, m_size);
        end
        if (cond !== 4'(m_cond)) begin
          n_bad++; $display("FAIL R3 cond: actual %0h expected %0h", cond, m_cond);
        end
        if (tag_v !== (m_tagv != 0) || (tag_v && tag !== 8'(m_tag))) begin
          n_bad++; $display("FAIL R11 tag: actual %0d/%0h expected %0d/%0h", tag_v, tag, m_tagv, m_tag);
        end
      end
    end
  end

  task automatic load(input logic [31:0] w, input logic n, input logic [7:0] st);
    @(negedge clk);
    wv = 1'b1; word = w; narrow = n; cb_hi = st[7:2]; cb_lo = st[1:0];
    @(negedge clk);
    wv = 1'b0;
  endtask

  task automatic pop();
    take = 1'b1;
    @(negedge clk);
    take = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 need_more", int'(need_more), 1);
    chk("R1 ready", int'(ready), 0);
    chk("R1 insn", int'(insn), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // full width
    load(32'hE1A0_0000, 1'b0, 8'h00);
    @(negedge clk);
    chk("R3 insn", int'(insn), 32'hE1A0_0000);
    chk("R3 size", int'(size), 4);
    chk("R3 cond", int'(cond), 4'hE);
    chk("R9 need_more after 4 bytes", int'(need_more), 1);
    repeat (3) @(negedge clk);
    chk("R12 held", int'(insn), 32'hE1A0_0000);
    pop();
    chk("R10 ready cleared", int'(ready), 0);
    chk("R10 insn cleared", int'(insn), 0);

    // 16-bit then straddling 32-bit
    load(32'hF000_4608, 1'b1, 8'h00);
    @(negedge clk);
    chk("R4 low half", int'(insn), 32'h0000_4608);
    chk("R6 size", int'(size), 2);
    chk("R6 cond", int'(cond), 4'hE);
    chk("R9 bytes remain", int'(need_more), 0);
    wv = 1'b1; word = 32'h1111_1111;   // R2: offered while need_more low
    @(negedge clk);
    wv = 1'b0;
    chk("R2 ignored load", int'(insn), 32'h0000_4608);
    pop();
    @(negedge clk);
    chk("R8 pending not ready", int'(ready), 0);
    chk("R8 need_more", int'(need_more), 1);
    load(32'h2001_F800, 1'b1, 8'h00);
    @(negedge clk);
    chk("R8 joined", int'(insn), 32'hF000_F800);
    chk("R8 size", int'(size), 4);
    pop();
    @(negedge clk);
    chk("R4 high half", int'(insn), 32'h0000_2001);
    chk("R9 used up", int'(need_more), 1);
    pop();

    // aligned wide and length boundary
    load(32'h4FF0_E92D, 1'b1, 8'h00);
    @(negedge clk);
    chk("R7 swapped", int'(insn), 32'hE92D_4FF0);
    chk("R5 wide size", int'(size), 4);
    pop();
    load(32'h0000_E7FE, 1'b1, 8'h00);
    @(negedge clk);
    chk("R5 11100 is narrow", int'(insn), 32'h0000_E7FE);
    chk("R5 narrow size", int'(size), 2);
    pop();
    @(negedge clk);
    pop();

    // conditional-block tagging
    load(32'h2001_2000, 1'b1, 8'h1C);
    @(negedge clk);
    chk("R11 tag valid", int'(tag_v), 1);
    chk("R11 tag first", int'(tag), 8'h1C);
    pop();
    @(negedge clk);
    chk("R11 tag advanced", int'(tag), 8'h18);
    pop();
    load(32'h4608_4608, 1'b1, 8'h18);
    @(negedge clk);
    chk("R11 tag", int'(tag), 8'h18);
    pop();
    @(negedge clk);
    chk("R11 state expired", int'(tag_v), 0);
    pop();
    load(32'hE1A0_0000, 1'b0, 8'h1C);
    @(negedge clk);
    chk("R11 full width untagged", int'(tag_v), 0);
    pop();

    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wv = ($urandom % 2) == 0;
      word = 32'h0;
      for (int h = 0; h < 2; h++) begin
        logic [15:0] half;
        if ($urandom % 3 == 0) half = {5'(29 + ($urandom % 3)), 11'($urandom)};
        else half = 16'($urandom) & 16'h7FFF;
        word = word | (32'(half) << (16 * h));
      end
      narrow = (m_pend != 0) ? 1'b1 : (($urandom % 4) != 0);
      if ($urandom % 3 == 0) {cb_hi, cb_lo} = 8'($urandom);
      else {cb_hi, cb_lo} = 8'h00;
      take = (m_ready != 0) && (($urandom % 2) == 0);
    end
    @(negedge clk);
    wv = 1'b0; take = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule